// File: doc/BRIEF.md
# Programmable Qualified Event Counter

This block is one programmable performance counter for a processor core. Every clock cycle it receives a bank of event lines, grouped into sources of eight sub-event lines each, together with the privilege level the core is running at. A configuration word picks one source by its 8-bit event code and picks sub-events inside it with an 8-bit unit mask. The block then counts how many of the chosen lines are asserted in that cycle and qualifies the result. It can compare that count against a threshold, invert the comparison, count only rising edges of the qualified condition, and filter by privilege ring. The qualified amount is added to a 40-bit counter.

Software writes the configuration word and can read or overwrite the counter value at any time. When the counter wraps it sets a sticky overflow flag and can raise a one-cycle interrupt pulse. Each counter instance carries an index parameter. Event codes that are reserved for a different counter index count nothing on this one. The source mux is small and parameterised, and it stands in for a full event decoder.

Top module: `perf_event_counter`

## Requirements
- R1: After reset the counter value is 0, the overflow flag is 0, the interrupt is 0 and counting is disabled.
- R2: Configuration word layout is: code [7:0], unit mask [15:8], threshold [23:16], enable bit 24, OS bit 25, user bit 26, edge bit 27, invert bit 28, interrupt enable bit 29. A code n below NUM_SRC selects lines [8n+7:8n]. Unit-mask bit j admits sub-line j, so ORed mask bits combine sub-events (0x0C covers the lines of 0x04 and 0x08). The per-cycle count is the number of admitted lines that are high. A code of NUM_SRC or above counts nothing.
- R3: With a nonzero threshold and invert clear, the counter adds 1 in each cycle whose count is greater than or equal to the threshold, and adds 0 otherwise.
- R4: With a nonzero threshold and invert set, the counter adds 1 in each cycle whose count is below the threshold.
- R5: With edge set, the counter adds 1 only in a cycle where the qualified condition is true and was false in the previous cycle. The condition is the R3/R4 comparison, or a nonzero count when the threshold is 0.
- R6: The OS bit admits events at privilege level 0. The user bit admits events at levels 1, 2 and 3.
- R7: When both the OS bit and the user bit are clear, all privilege levels are admitted.
- R8: Code ONLY0_CODE (default 0x02) counts only when CTR_INDEX is 0. Code ONLY1_CODE (default 0x03) counts only when CTR_INDEX is 1. The default CTR_INDEX is 0.
- R9: With threshold 0 and edge clear, the counter adds the raw per-cycle count (0 to 8), and invert has no effect.
- R10: A wrap from all-ones past zero leaves the low 40 bits of the sum and sets the sticky overflow flag. If interrupt enable is set, it also drives irq high for exactly that one cycle.
- R11: A counter write in a cycle replaces the value with the written data and discards that cycle's increment.
- R12: While enable is clear, the edge history is cleared. Re-enabling while the condition is already true therefore counts one edge.
- R13: While enable is clear, the counter holds its value. Events and privilege presented in a cycle show up in ctr_value after the next rising clock edge. A configuration write applies to the events of the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 30 | Configuration word (layout in R2) |
| ctr_we | input | 1 | Counter write strobe |
| ctr_wdata | input | 40 | Counter write data |
| priv_level | input | 2 | Current privilege level, 0 to 3 |
| evt_lines | input | 32 | Per-cycle event lines, eight per source |
| ctr_value | output | 40 | Counter value for software read |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | One-cycle overflow interrupt |

## Verification
Every result of a cycle is due at the first rising edge after that cycle's inputs: the counter value, the overflow flag and the interrupt pulse all appear then. A configuration word written at that same edge only affects the cycle after it. The internal reset releases two clocks after rst_n rises. The bench drives each cycle's inputs on a falling edge and advances its reference model at the rising edge using the configuration that was in force before it. It then compares all three outputs on the following falling edge, so each comparison sits exactly one register stage behind the stimulus.

// File: rtl/pec_pkg.sv
package pec_pkg;

  localparam int CODE_W   = 8;
  localparam int UMASK_W  = 8;
  localparam int THRESH_W = 8;

  typedef struct packed {
    logic                int_en;
    logic                invert;
    logic                edge_en;
    logic                usr_en;
    logic                os_en;
    logic                enable;
    logic [THRESH_W-1:0] thresh;
    logic [UMASK_W-1:0]  umask;
    logic [CODE_W-1:0]   code;
  } pec_cfg_t;

  localparam int CFG_W = $bits(pec_cfg_t);

endpackage

// File: rtl/pec_event_select.sv
module pec_event_select
  import pec_pkg::*;
#(
  parameter int NUM_SRC     = 4,
  parameter int CTR_INDEX   = 0,
  parameter int ONLY0_CODE  = 2,
  parameter int ONLY1_CODE  = 3,
  localparam int LINES_W    = NUM_SRC * UMASK_W,
  localparam int CNT_W      = $clog2(UMASK_W + 1)
) (
  input  logic [LINES_W-1:0] evt_lines,
  input  logic [CODE_W-1:0]  code,
  input  logic [UMASK_W-1:0] umask,
  output logic [CNT_W-1:0]   cnt
);

  logic [CNT_W-1:0] src_cnt [NUM_SRC];
  logic             code_legal;

  // one masked population count per source
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    always_comb begin
      src_cnt[s] = '0;
      for (int j = 0; j < UMASK_W; j++) begin
        src_cnt[s] = src_cnt[s] + CNT_W'(evt_lines[s*UMASK_W + j] & umask[j]);
      end
    end
  end

  always_comb begin
    code_legal = (int'(code) < NUM_SRC);
    if (int'(code) == ONLY0_CODE && CTR_INDEX != 0) code_legal = 1'b0;
    if (int'(code) == ONLY1_CODE && CTR_INDEX != 1) code_legal = 1'b0;
    cnt = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (code_legal && int'(code) == s) cnt = src_cnt[s];
    end
  end

endmodule

// File: rtl/pec_qualify.sv
module pec_qualify
  import pec_pkg::*;
#(
  parameter int CNT_W = 4,
  localparam int CMP_W = (THRESH_W > CNT_W) ? THRESH_W : CNT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CNT_W-1:0]    cnt,
  input  logic [1:0]          priv_level,
  input  logic                enable,
  input  logic                os_en,
  input  logic                usr_en,
  input  logic                edge_en,
  input  logic                invert,
  input  logic [THRESH_W-1:0] thresh,
  output logic [CNT_W-1:0]    inc
);

  logic prev_q, prev_d;
  logic os_eff, usr_eff, ring_ok, thr_zero, cmp_hit, cond;
  logic [CMP_W-1:0] cnt_x, thr_x;

  always_comb begin
    os_eff   = os_en  | ~(os_en | usr_en);
    usr_eff  = usr_en | ~(os_en | usr_en);
    ring_ok  = (priv_level == 2'd0) ? os_eff : usr_eff;
    thr_zero = (thresh == '0);
    cnt_x    = CMP_W'(cnt);
    thr_x    = CMP_W'(thresh);
    cmp_hit  = invert ? (cnt_x < thr_x) : (cnt_x >= thr_x);
    cond     = ring_ok & (thr_zero ? (cnt != '0) : cmp_hit);
    prev_d   = enable & cond;

    if (!enable)       inc = '0;
    else if (edge_en)  inc = CNT_W'(cond & ~prev_q);
    else if (thr_zero) inc = ring_ok ? cnt : '0;
    else               inc = CNT_W'(cond);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

endmodule

// File: rtl/pec_accum.sv
module pec_accum #(
  parameter int CTR_W = 40,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] inc,
  input  logic             ctr_we,
  input  logic [CTR_W-1:0] ctr_wdata,
  input  logic             int_en,
  output logic [CTR_W-1:0] ctr_q,
  output logic             ovf_q,
  output logic             irq_q
);

  logic [CTR_W:0]   sum;
  logic [CTR_W-1:0] ctr_d;
  logic             ctr_ld, wrap, ovf_d, irq_d;

  always_comb begin
    sum    = {1'b0, ctr_q} + (CTR_W+1)'(inc);
    wrap   = ~ctr_we & sum[CTR_W];
    ctr_ld = ctr_we | (inc != '0);
    ctr_d  = ctr_we ? ctr_wdata : sum[CTR_W-1:0];
    ovf_d  = ovf_q | wrap;
    irq_d  = wrap & int_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr_q <= '0;
      ovf_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (ctr_ld) ctr_q <= ctr_d;
      ovf_q <= ovf_d;
      irq_q <= irq_d;
    end
  end

endmodule

// File: rtl/perf_event_counter.sv
module perf_event_counter
  import pec_pkg::*;
#(
  parameter int NUM_SRC    = 4,
  parameter int CTR_W      = 40,
  parameter int CTR_INDEX  = 0,
  parameter int ONLY0_CODE = 2,
  parameter int ONLY1_CODE = 3,
  localparam int LINES_W   = NUM_SRC * UMASK_W,
  localparam int CNT_W     = $clog2(UMASK_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CFG_W-1:0]   cfg_wdata,
  input  logic               ctr_we,
  input  logic [CTR_W-1:0]   ctr_wdata,
  input  logic [1:0]         priv_level,
  input  logic [LINES_W-1:0] evt_lines,
  output logic [CTR_W-1:0]   ctr_value,
  output logic               ovf_flag,
  output logic               irq
);

  logic [1:0]       rst_sync;
  logic             rst_sync_n;
  pec_cfg_t         cfg_q, cfg_d;
  logic             cfg_en_w, cfg_edge_w;
  logic [CNT_W-1:0] evt_cnt, inc;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  always_comb cfg_d = cfg_we ? pec_cfg_t'(cfg_wdata) : cfg_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cfg_q <= '0;
    else             cfg_q <= cfg_d;
  end

  assign cfg_en_w   = cfg_q.enable;
  assign cfg_edge_w = cfg_q.edge_en;

  pec_event_select #(
    .NUM_SRC(NUM_SRC), .CTR_INDEX(CTR_INDEX),
    .ONLY0_CODE(ONLY0_CODE), .ONLY1_CODE(ONLY1_CODE)
  ) u_sel (
    .evt_lines(evt_lines), .code(cfg_q.code), .umask(cfg_q.umask), .cnt(evt_cnt)
  );

  pec_qualify #(.CNT_W(CNT_W)) u_qual (
    .clk(clk), .rst_n(rst_sync_n), .cnt(evt_cnt), .priv_level(priv_level),
    .enable(cfg_en_w), .os_en(cfg_q.os_en), .usr_en(cfg_q.usr_en),
    .edge_en(cfg_edge_w), .invert(cfg_q.invert), .thresh(cfg_q.thresh), .inc(inc)
  );

  pec_accum #(.CTR_W(CTR_W), .CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_sync_n), .inc(inc), .ctr_we(ctr_we),
    .ctr_wdata(ctr_wdata), .int_en(cfg_q.int_en),
    .ctr_q(ctr_value), .ovf_q(ovf_flag), .irq_q(irq)
  );

endmodule

// File: rtl/pec_checker.sv
module pec_checker #(
  parameter int CTR_W = 40,
  parameter int LINES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctr_we,
  input logic [CTR_W-1:0] ctr_wdata,
  input logic [CTR_W-1:0] ctr_value,
  input logic             ovf_flag,
  input logic             irq,
  input logic             cfg_en,
  input logic             cfg_edge
);

  // R13: disabled counter without a write keeps its value
  assert_hold_off_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(cfg_en) && !$past(ctr_we)) |-> $stable(ctr_value));

  // R11: a write always lands exactly
  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ctr_we)) |-> (ctr_value == $past(ctr_wdata)));

  // R9: a single cycle never adds more than the number of sub-lines
  assert_step_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(ctr_we)) |->
      (CTR_W'(ctr_value - $past(ctr_value)) <= CTR_W'(LINES)));

  // R5: edge mode adds at most one
  assert_edge_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(ctr_we) && $past(cfg_edge)) |->
      (CTR_W'(ctr_value - $past(ctr_value)) <= CTR_W'(1)));

  // R10: interrupt is a single-cycle pulse, flag is sticky and accompanies it
  assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);
  assert_irq_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ovf_flag);

endmodule

bind perf_event_counter pec_checker #(.CTR_W(CTR_W), .LINES(pec_pkg::UMASK_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .ctr_we(ctr_we), .ctr_wdata(ctr_wdata),
  .ctr_value(ctr_value), .ovf_flag(ovf_flag), .irq(irq),
  .cfg_en(cfg_en_w), .cfg_edge(cfg_edge_w)
);

// File: tb/sim_perf_event_counter.sv
module sim_perf_event_counter;

  localparam int CW = 40;
  localparam logic [CW-1:0] ALL1 = {CW{1'b1}};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [29:0]   cfg_wdata;
  logic          ctr_we;
  logic [CW-1:0] ctr_wdata;
  logic [1:0]    priv_level;
  logic [31:0]   evt_lines;
  logic [CW-1:0] ctr_value;
  logic          ovf_flag, irq;

  int checks = 0;
  int fails  = 0;

  // reference model state
  logic [29:0]   m_cfg;
  logic [CW-1:0] m_ctr;
  logic          m_prev, m_ovf, m_irq;

  always #5 clk = ~clk;

  perf_event_counter u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ctr_we(ctr_we), .ctr_wdata(ctr_wdata), .priv_level(priv_level),
    .evt_lines(evt_lines), .ctr_value(ctr_value), .ovf_flag(ovf_flag), .irq(irq)
  );

  function automatic logic [29:0] mkcfg(input logic [7:0] code, input logic [7:0] um,
      input logic [7:0] thr, input logic en, input logic os, input logic usr,
      input logic edg, input logic inv, input logic ie);
    return {ie, inv, edg, usr, os, en, thr, um, code};
  endfunction

  function automatic int ev_count(input logic [31:0] lines, input logic [7:0] code,
                                  input logic [7:0] um);
    int n = 0;
    if (code >= 8'd4 || code == 8'd3) return 0;  // R8: code 3 belongs to index 1
    for (int j = 0; j < 8; j++) n += int'(lines[code*8 + j] & um[j]);
    return n;
  endfunction

  task automatic model_edge(input logic [31:0] lines, input logic [1:0] pr,
                            input logic cwe, input logic [29:0] cw,
                            input logic kwe, input logic [CW-1:0] kw);
    int n, thr, inc;
    logic en, os, usr, edg, inv, ie, both, ok, cond;
    logic [CW:0] s;
    n   = ev_count(lines, m_cfg[7:0], m_cfg[15:8]);
    thr = int'(m_cfg[23:16]);
    en = m_cfg[24]; os = m_cfg[25]; usr = m_cfg[26];
    edg = m_cfg[27]; inv = m_cfg[28]; ie = m_cfg[29];
    both = !os && !usr;
    ok   = (pr == 2'd0) ? (os || both) : (usr || both);
    cond = ok && ((thr == 0) ? (n != 0) : (inv ? (n < thr) : (n >= thr)));
    if (!en)            inc = 0;
    else if (edg)       inc = int'(cond && !m_prev);
    else if (thr == 0)  inc = ok ? n : 0;
    else                inc = int'(cond);
    m_prev = en && cond;
    m_irq  = 1'b0;
    if (kwe) m_ctr = kw;
    else begin
      s = {1'b0, m_ctr} + (CW+1)'(inc);
      m_ctr = s[CW-1:0];
      if (s[CW]) begin m_ovf = 1'b1; m_irq = ie; end
    end
    if (cwe) m_cfg = cw;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at falling edge, model at rising edge, compare at next falling edge
  task automatic cyc(input string tag, input logic [31:0] lines, input logic [1:0] pr,
                     input logic cwe, input logic [29:0] cw,
                     input logic kwe, input logic [CW-1:0] kw);
    evt_lines = lines; priv_level = pr;
    cfg_we = cwe; cfg_wdata = cw; ctr_we = kwe; ctr_wdata = kw;
    @(posedge clk);
    model_edge(lines, pr, cwe, cw, kwe, kw);
    @(negedge clk);
    cfg_we = 1'b0; ctr_we = 1'b0;
    chk({tag, " ctr"}, 64'(ctr_value), 64'(m_ctr));
    chk({tag, " ovf"}, 64'(ovf_flag), 64'(m_ovf));
    chk({tag, " irq"}, 64'(irq), 64'(m_irq));
  endtask

  task automatic setcfg(input logic [29:0] cw);
    cyc("cfg", 32'h0, 2'd0, 1'b1, cw, 1'b0, '0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_we = 1'b0; ctr_we = 1'b0; cfg_wdata = '0; ctr_wdata = '0;
    evt_lines = '0; priv_level = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_cfg = '0; m_ctr = '0; m_prev = 1'b0; m_ovf = 1'b0; m_irq = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    do_reset();
    // R1
    chk("R1 ctr", 64'(ctr_value), 64'd0);
    chk("R1 ovf", 64'(ovf_flag), 64'd0);
    chk("R1 irq", 64'(irq), 64'd0);
    cyc("R1 disabled", 32'hFFFF_FFFF, 2'd0, 1'b0, '0, 1'b0, '0);

    // R2: source 1, mask 0x0C combines two sub-lines; threshold 0 raw
    setcfg(mkcfg(8'd1, 8'h0C, 8'd0, 1, 0, 0, 0, 0, 0));
    cyc("R2 combined mask", 32'h0000_0C00, 2'd0, 0, '0, 0, '0);
    cyc("R2 one sub-line", 32'h0000_0400, 2'd0, 0, '0, 0, '0);
    cyc("R2 unmasked lines", 32'hFFFF_F3FF, 2'd0, 0, '0, 0, '0);
    // R9: raw count with invert ignored
    setcfg(mkcfg(8'd0, 8'hFF, 8'd0, 1, 0, 0, 0, 1, 0));
    cyc("R9 raw 8", 32'h0000_00FF, 2'd0, 0, '0, 0, '0);
    cyc("R9 raw 3", 32'h0000_0007, 2'd3, 0, '0, 0, '0);
    // R3 threshold
    setcfg(mkcfg(8'd0, 8'hFF, 8'd3, 1, 0, 0, 0, 0, 0));
    cyc("R3 below", 32'h0000_0003, 2'd0, 0, '0, 0, '0);
    cyc("R3 equal", 32'h0000_0007, 2'd0, 0, '0, 0, '0);
    cyc("R3 above", 32'h0000_00F7, 2'd0, 0, '0, 0, '0);
    // R4 invert
    setcfg(mkcfg(8'd0, 8'hFF, 8'd3, 1, 0, 0, 0, 1, 0));
    cyc("R4 below", 32'h0000_0001, 2'd0, 0, '0, 0, '0);
    cyc("R4 equal", 32'h0000_0007, 2'd0, 0, '0, 0, '0);
    // R6 / R7 privilege
    setcfg(mkcfg(8'd0, 8'hFF, 8'd0, 1, 1, 0, 0, 0, 0));
    cyc("R6 os at ring 2", 32'h0000_0003, 2'd2, 0, '0, 0, '0);
    cyc("R6 os at ring 0", 32'h0000_0003, 2'd0, 0, '0, 0, '0);
    setcfg(mkcfg(8'd0, 8'hFF, 8'd0, 1, 0, 1, 0, 0, 0));
    cyc("R6 usr at ring 0", 32'h0000_0003, 2'd0, 0, '0, 0, '0);
    cyc("R6 usr at ring 3", 32'h0000_0003, 2'd3, 0, '0, 0, '0);
    setcfg(mkcfg(8'd0, 8'hFF, 8'd0, 1, 0, 0, 0, 0, 0));
    cyc("R7 default ring 0", 32'h0000_0001, 2'd0, 0, '0, 0, '0);
    cyc("R7 default ring 1", 32'h0000_0001, 2'd1, 0, '0, 0, '0);
    // R8 restricted codes on index 0
    setcfg(mkcfg(8'd3, 8'hFF, 8'd0, 1, 0, 0, 0, 0, 0));
    cyc("R8 other-index code", 32'hFFFF_FFFF, 2'd0, 0, '0, 0, '0);
    setcfg(mkcfg(8'd2, 8'hFF, 8'd0, 1, 0, 0, 0, 0, 0));
    cyc("R8 own-index code", 32'h00F0_0000, 2'd0, 0, '0, 0, '0);
    setcfg(mkcfg(8'd9, 8'hFF, 8'd0, 1, 0, 0, 0, 0, 0));
    cyc("R2 unknown code", 32'hFFFF_FFFF, 2'd0, 0, '0, 0, '0);
    // R5 edge and R12 re-enable
    setcfg(mkcfg(8'd0, 8'hFF, 8'd1, 1, 0, 0, 1, 0, 0));
    cyc("R5 rise", 32'h0000_0003, 2'd0, 0, '0, 0, '0);
    cyc("R5 held", 32'h0000_0003, 2'd0, 0, '0, 0, '0);
    cyc("R5 held", 32'h0000_000F, 2'd0, 0, '0, 0, '0);
    cyc("R5 low", 32'h0000_0000, 2'd0, 0, '0, 0, '0);
    cyc("R5 rise again", 32'h0000_0001, 2'd0, 0, '0, 0, '0);
    cyc("R13 disable", 32'h0000_0001, 2'd0, 1, mkcfg(8'd0, 8'hFF, 8'd1, 0, 0, 0, 1, 0, 0), 0, '0);
    cyc("R13 hold", 32'h0000_0001, 2'd0, 1, mkcfg(8'd0, 8'hFF, 8'd1, 1, 0, 0, 1, 0, 0), 0, '0);
    cyc("R12 re-enable edge", 32'h0000_0001, 2'd0, 0, '0, 0, '0);
    cyc("R12 no repeat", 32'h0000_0001, 2'd0, 0, '0, 0, '0);
    // R11 write priority
    setcfg(mkcfg(8'd0, 8'hFF, 8'd0, 1, 0, 0, 0, 0, 0));
    cyc("R11 write wins", 32'h0000_0007, 2'd0, 0, '0, 1, 40'd100);
    cyc("R11 after write", 32'h0000_0007, 2'd0, 0, '0, 0, '0);
    // R10 overflow with interrupt
    setcfg(mkcfg(8'd0, 8'hFF, 8'd0, 1, 0, 0, 0, 0, 1));
    cyc("R10 preload", 32'h0, 2'd0, 0, '0, 1, ALL1 - 40'd2);
    cyc("R10 to all-ones", 32'h0000_0003, 2'd0, 0, '0, 0, '0);
    cyc("R10 wrap", 32'h0000_0003, 2'd0, 0, '0, 0, '0);
    cyc("R10 pulse ends", 32'h0000_0001, 2'd0, 0, '0, 0, '0);
    // R10 overflow with interrupt disabled
    do_reset();
    setcfg(mkcfg(8'd0, 8'hFF, 8'd0, 1, 0, 0, 0, 0, 0));
    cyc("R10 preload", 32'h0, 2'd0, 0, '0, 1, ALL1);
    cyc("R10 wrap no irq", 32'h0000_0001, 2'd0, 0, '0, 0, '0);

    // constrained random mix
    do_reset();
    setcfg(mkcfg(8'd0, 8'hFF, 8'd0, 1, 0, 0, 0, 0, 1));
    for (int i = 0; i < 3000; i++) begin
      logic cwe, kwe;
      logic [29:0] cw;
      logic [CW-1:0] kw;
      cwe = ($urandom % 16) == 0;
      kwe = ($urandom % 64) == 0;
      cw  = mkcfg(8'($urandom % 6), 8'($urandom), 8'($urandom % 10),
                  ($urandom % 8) != 0, 1'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom));
      kw  = (($urandom % 2) == 0) ? (ALL1 - 40'($urandom % 40)) : 40'($urandom);
      cyc("R13 random", $urandom, 2'($urandom), cwe, cw, kwe, kw);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule